// File: doc/BRIEF.md
# Fast A20 Gate and Alternate Reset Port

This block is a one-byte system control register for a PC-compatible chipset, decoded at I/O address 0x92 on a simple strobe bus. Software uses it for three things. It can open or close the A20 address gate. It can fire a short alternate CPU reset without going through the keyboard controller. It can set a CMOS security lock that no software write can undo. The same byte also drives an activity light and reports whether a watchdog timeout has occurred. The watchdog status comes in on an input pin.

Two reset domains are kept apart. The power-on reset `por_n` clears everything. The CPU reset `cpu_rst_n` clears only the A20 gate and the light bits. The lock bit, the reset-method bit (bit 0) and the pulse generator are not touched by a CPU reset. Firmware can therefore read bit 0 after a restart and tell that the fast path caused it. A pulse already under way is not cut short by the CPU reset that the pulse itself triggers.

The fast-reset pulse comes from a two-state machine. State PS_IDLE holds the output low. Transition IDLE_TO_DRIVE is taken when an accepted write has bit 0 set. State PS_DRIVE holds the output high while a counter advances once per cycle. Transition DRIVE_TO_IDLE is taken when the counter reaches PULSE_LEN-1. Start requests that arrive while in PS_DRIVE are ignored.

Top module: `sysctl_a20_reset`

## Requirements
- R1: An access is accepted only when `io_addr` equals 0x0092 and `io_be` equals 4'b0001, with the byte carried on `io_wdata[7:0]`. Any other address leaves all register state and outputs unchanged.
- R2: A read or write at 0x0092 with a nonzero `io_be` other than 4'b0001 changes no state. It raises `io_err` for exactly the one cycle after the strobe. `io_err` is 0 at all other times.
- R3: An accepted write with bit 0 set drives `fast_reset` high for exactly 4 cycles, starting in the cycle after the write. A further such write while the pulse is high does not extend or restart it.
- R4: An accepted write with bit 0 clear loads bit 1 into `a20_gate` (1 = enabled), visible the cycle after the write. When bit 0 is set, `a20_gate` keeps its value. Bit 1 reads back the gate state.
- R5: Bit 3 (lock) is set by writing 1. Writes of 0 and CPU resets do not clear it. Only `por_n` clears it.
- R6: Bit 0 reads back the bit 0 of the last accepted write. It survives `cpu_rst_n` and is cleared only by `por_n`.
- R7: Bits 7 and 6 are stored, and `activity_led` is their OR. A CPU reset clears them and `a20_gate`.
- R8: Bit 4 reads as `wdog_timeout` at the read strobe. Bits 5 and 2 always read 0.
- R9: `io_rdata` holds the register byte in the cycle after an accepted read strobe and is 0 in every other cycle.
- R10: After `por_n`, every register bit is 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| cpu_rst_n | input | 1 | CPU reset, asynchronous, active low |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data, register byte on bits 7:0 |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| wdog_timeout | input | 1 | Watchdog timeout status |
| io_rdata | output | 8 | Registered read data |
| io_err | output | 1 | Rejected-width access flag |
| a20_gate | output | 1 | A20 gate enable |
| fast_reset | output | 1 | Alternate CPU reset pulse |
| activity_led | output | 1 | Activity light |

## Verification
Two functions can share one cycle. A single write may both request the fast reset and carry a new A20 value. A second write may also land while an earlier pulse is still high. Directed writes with both bits 0 and 1 set are issued, plus back-to-back bit-0 writes, and random traffic is mixed with CPU resets. A bench model predicts the gate, the pulse length and the read-back byte, and each output is compared every cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // Bit positions inside the control byte; software depends on these.
    localparam int unsigned BIT_FAST_RST = 0;
    localparam int unsigned BIT_A20      = 1;
    localparam int unsigned BIT_SPARE_LO = 2;
    localparam int unsigned BIT_LOCK     = 3;
    localparam int unsigned BIT_WDOG     = 4;
    localparam int unsigned BIT_SPARE_HI = 5;
    localparam int unsigned BIT_LED_LO   = 6;
    localparam int unsigned BIT_LED_HI   = 7;
    localparam int unsigned REG_W        = 8;

    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_DRIVE = 1'b1
    } pulse_state_e;

    typedef struct packed {
        logic wr;    // accepted byte write
        logic rd;    // accepted byte read
        logic bad;   // hit with unsupported width
    } access_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 16,
    parameter int unsigned        BE_W      = 4,
    parameter logic [ADDR_W-1:0]  PORT_ADDR = 16'h0092
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output access_t           acc_o,
    output logic              err_o
);

    logic hit;
    logic single;
    logic any_lane;
    logic err_q;

    assign hit      = (addr_i == PORT_ADDR);
    assign single   = (be_i == BE_W'(1));
    assign any_lane = |be_i;

    always_comb begin
        acc_o.wr  = hit && single && wr_i;
        acc_o.rd  = hit && single && rd_i && !wr_i;
        acc_o.bad = hit && any_lane && !single && (rd_i || wr_i);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) err_q <= 1'b0;
        else        err_q <= acc_o.bad;
    end

    assign err_o = err_q;

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        (err_q && !acc_o.bad) |=> !err_q); // R2

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             cpu_rst_n,
    input  access_t          acc_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             wdog_i,
    output logic [REG_W-1:0] rd_val_o,
    output logic             start_o,
    output logic             a20_o,
    output logic             led_o
);

    logic       cpu_dom_n;
    logic       a20_q;
    logic [1:0] led_q;
    logic       lock_q;
    logic       method_q;
    logic       unused_bits;

    assign cpu_dom_n   = por_n & cpu_rst_n;
    assign unused_bits = ^{wdata_i[BIT_SPARE_HI], wdata_i[BIT_WDOG], wdata_i[BIT_SPARE_LO]};

    // CPU reset domain: gate and light bits
    always_ff @(posedge clk or negedge cpu_dom_n) begin
        if (!cpu_dom_n) begin
            a20_q <= 1'b0;
            led_q <= 2'b00;
        end else if (acc_i.wr) begin
            led_q <= wdata_i[BIT_LED_HI:BIT_LED_LO];
            if (!wdata_i[BIT_FAST_RST]) a20_q <= wdata_i[BIT_A20];
        end
    end

    // Power-on domain: lock and reset-method bits
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock_q   <= 1'b0;
            method_q <= 1'b0;
        end else if (acc_i.wr) begin
            lock_q   <= lock_q | wdata_i[BIT_LOCK];
            method_q <= wdata_i[BIT_FAST_RST];
        end
    end

    always_comb begin
        rd_val_o               = '0;
        rd_val_o[BIT_FAST_RST] = method_q;
        rd_val_o[BIT_A20]      = a20_q;
        rd_val_o[BIT_LOCK]     = lock_q;
        rd_val_o[BIT_WDOG]     = wdog_i;
        rd_val_o[BIT_LED_HI:BIT_LED_LO] = led_q;
    end

    assign start_o = acc_i.wr && wdata_i[BIT_FAST_RST];
    assign a20_o   = a20_q;
    assign led_o   = |led_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        lock_q |=> lock_q); // R5

    AST_A20_SKIP: assert property (@(posedge clk) disable iff (!cpu_dom_n)
        start_o |=> $stable(a20_q)); // R4

    AST_METHOD_CPU_RST: assert property (@(posedge clk) disable iff (!por_n)
        (!cpu_rst_n && !acc_i.wr) |=> $stable(method_q)); // R6

endmodule

// File: rtl/sysctl_pulse.sv
module sysctl_pulse
    import sysctl_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic start_i,
    output logic pulse_o
);

    localparam int unsigned CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    pulse_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_IDLE: begin
                cnt_d = '0;
                if (start_i) state_d = PS_DRIVE;        // IDLE_TO_DRIVE
            end
            PS_DRIVE: begin
                if (cnt_q == LAST) begin
                    state_d = PS_IDLE;                  // DRIVE_TO_IDLE
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            PS_IDLE:  pulse_o = 1'b0;
            PS_DRIVE: pulse_o = 1'b1;
            default:  pulse_o = 1'b0;
        endcase
    end

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pulse_o) |-> $past(start_i)); // R3

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (pulse_o && cnt_q != LAST) |=> pulse_o); // R3

    AST_PULSE_END: assert property (@(posedge clk) disable iff (!por_n)
        (pulse_o && cnt_q == LAST) |=> !pulse_o); // R3

endmodule

// File: rtl/sysctl_a20_reset.sv
module sysctl_a20_reset
    import sysctl_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter int unsigned       BE_W      = 4,
    parameter int unsigned       DATA_W    = 32,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092,
    parameter int unsigned       PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              cpu_rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BE_W-1:0]   io_be,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              wdog_timeout,
    output logic [REG_W-1:0]  io_rdata,
    output logic              io_err,
    output logic              a20_gate,
    output logic              fast_reset,
    output logic              activity_led
);

    access_t          acc;
    logic [REG_W-1:0] rd_val;
    logic [REG_W-1:0] rdata_q;
    logic             start;
    logic             unused_wide;

    assign unused_wide = ^io_wdata[DATA_W-1:REG_W];

    sysctl_decode #(
        .ADDR_W    (ADDR_W),
        .BE_W      (BE_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .clk    (clk),
        .por_n  (por_n),
        .addr_i (io_addr),
        .be_i   (io_be),
        .rd_i   (io_rd),
        .wr_i   (io_wr),
        .acc_o  (acc),
        .err_o  (io_err)
    );

    sysctl_regs u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .cpu_rst_n (cpu_rst_n),
        .acc_i     (acc),
        .wdata_i   (io_wdata[REG_W-1:0]),
        .wdog_i    (wdog_timeout),
        .rd_val_o  (rd_val),
        .start_o   (start),
        .a20_o     (a20_gate),
        .led_o     (activity_led)
    );

    sysctl_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk     (clk),
        .por_n   (por_n),
        .start_i (start),
        .pulse_o (fast_reset)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      rdata_q <= '0;
        else if (acc.rd) rdata_q <= rd_val;
        else             rdata_q <= '0;
    end

    assign io_rdata = rdata_q;

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        !$past(io_rd) |-> (io_rdata == '0)); // R9

    AST_WIDE_NO_EFFECT: assert property (@(posedge clk) disable iff (!por_n || !cpu_rst_n)
        (io_wr && io_addr == PORT_ADDR && io_be != BE_W'(1)) |=> $stable(a20_gate)); // R2

    AST_FOREIGN_NO_EFFECT: assert property (@(posedge clk) disable iff (!por_n || !cpu_rst_n)
        (io_addr != PORT_ADDR) |=> ($stable(a20_gate) && $stable(activity_led))); // R1

endmodule

// File: tb/sysctl_a20_reset_test.sv
`timescale 1ns/1ps
module sysctl_a20_reset_test;

    logic        clk = 1'b0;
    logic        por_n, cpu_rst_n;
    logic [15:0] io_addr;
    logic [3:0]  io_be;
    logic [31:0] io_wdata;
    logic        io_rd, io_wr, wdog_timeout;
    logic [7:0]  io_rdata;
    logic        io_err, a20_gate, fast_reset, activity_led;

    always #4 clk = ~clk;

    sysctl_a20_reset uut (
        .clk(clk), .por_n(por_n), .cpu_rst_n(cpu_rst_n),
        .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .wdog_timeout(wdog_timeout),
        .io_rdata(io_rdata), .io_err(io_err), .a20_gate(a20_gate),
        .fast_reset(fast_reset), .activity_led(activity_led)
    );

    int n_tests = 0;
    int n_fail  = 0;

    bit       m_a20, m_lock, m_flag, m_err;
    bit [1:0] m_led;
    bit [7:0] m_rdata;
    int       m_rem;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [7:0] model_byte(bit wd);
        return {m_led, 1'b0, wd, m_lock, 1'b0, m_a20, m_flag};
    endfunction

    task automatic step(bit rd, bit wr, logic [15:0] a, logic [3:0] be, logic [31:0] d, bit wd);
        bit hit, one;
        io_rd = rd; io_wr = wr; io_addr = a; io_be = be; io_wdata = d; wdog_timeout = wd;
        @(posedge clk);
        hit = (a == 16'h0092);
        one = (be == 4'b0001);
        m_rdata = (hit && rd && !wr && one) ? model_byte(wd) : 8'h00;
        m_err   = hit && (rd || wr) && (be != 4'b0000) && !one;
        if (m_rem > 0) m_rem--;
        else if (hit && wr && one && d[0]) m_rem = 4;
        if (hit && wr && one) begin
            m_led = d[7:6];
            if (!d[0]) m_a20 = d[1];
            m_lock = m_lock | d[3];
            m_flag = d[0];
        end
        @(negedge clk);
        chk("R4 a20_gate", a20_gate, m_a20);
        chk("R7 activity_led", activity_led, |m_led);
        chk("R3 fast_reset", fast_reset, m_rem > 0);
        chk("R9 io_rdata", io_rdata, m_rdata);
        chk("R2 io_err", io_err, m_err);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 16'h0000, 4'b0000, 32'h0, 0);
    endtask

    task automatic wr8(logic [7:0] d);
        step(0, 1, 16'h0092, 4'b0001, {24'h0, d}, 0);
    endtask

    task automatic rd8(bit wd);
        step(1, 0, 16'h0092, 4'b0001, 32'h0, wd);
    endtask

    task automatic cpu_reset();
        cpu_rst_n = 1'b0;
        m_a20 = 0; m_led = 0;
        idle(1);
        cpu_rst_n = 1'b1;
    endtask

    task automatic power_on();
        por_n = 1'b0;
        m_a20 = 0; m_led = 0; m_lock = 0; m_flag = 0; m_rem = 0; m_rdata = 0; m_err = 0;
        @(negedge clk); @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit [31:0] r;
        r = $urandom(32'd4242);
        io_rd = 0; io_wr = 0; io_addr = 0; io_be = 0; io_wdata = 0; wdog_timeout = 0;
        cpu_rst_n = 1'b1;
        power_on();

        // R10: reset state
        chk("R10 a20", a20_gate, 0);
        chk("R10 fast_reset", fast_reset, 0);
        chk("R10 led", activity_led, 0);
        chk("R10 err", io_err, 0);
        rd8(0);
        chk("R10 read byte", io_rdata, 8'h00);

        // R4: open gate, read back
        wr8(8'h02);
        rd8(0);
        chk("R4 readback", io_rdata, 8'h02);

        // R3 + R4 in one write: pulse, gate unchanged even with bit1 clear
        wr8(8'h01);
        chk("R4 skip on fast reset", a20_gate, 1);
        idle(5);
        // both bits set, then a retrigger while the pulse runs
        wr8(8'h03);
        wr8(8'h01);
        idle(5);

        // R6: method bit survives cpu reset
        rd8(0);
        chk("R6 before cpu reset", io_rdata, 8'h03);
        cpu_reset();
        rd8(0);
        chk("R6 after cpu reset", io_rdata, 8'h01);

        // R5: lock sticky
        wr8(8'h08);
        wr8(8'h00);
        rd8(0);
        chk("R5 lock kept after write 0", io_rdata, 8'h08);
        cpu_reset();
        rd8(0);
        chk("R5 lock kept after cpu reset", io_rdata, 8'h08);
        power_on();
        rd8(0);
        chk("R5 lock cleared by power-on", io_rdata, 8'h00);

        // R8 + R7: spare bits, watchdog bit, light
        wr8(8'hE4);
        rd8(1);
        chk("R8 spare and wdog bits", io_rdata, 8'hD0);
        wr8(8'h40); chk("R7 light bit6", activity_led, 1);
        wr8(8'h80); chk("R7 light bit7", activity_led, 1);
        wr8(8'h00); chk("R7 light off", activity_led, 0);
        cpu_reset();

        // R1: other addresses ignored
        step(0, 1, 16'h0093, 4'b0001, 32'hCA, 0);
        step(0, 1, 16'h0192, 4'b0001, 32'hCA, 0);
        step(1, 0, 16'h0091, 4'b0001, 32'h0, 1);
        chk("R1 foreign read", io_rdata, 8'h00);
        rd8(0);
        chk("R1 state unchanged", io_rdata, 8'h00);

        // R2: wide accesses
        step(0, 1, 16'h0092, 4'b0011, 32'h0000_00C2, 0);
        chk("R2 wide write err", io_err, 1);
        step(1, 0, 16'h0092, 4'b1111, 32'h0, 0);
        chk("R2 wide read err", io_err, 1);
        chk("R2 wide read data", io_rdata, 8'h00);
        idle(1);
        chk("R2 err drops", io_err, 0);
        rd8(0);
        chk("R2 state unchanged", io_rdata, 8'h00);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [15:0] a;
            logic [3:0]  be;
            op = $urandom_range(0, 99);
            a  = ($urandom_range(0, 9) < 8) ? 16'h0092 : 16'($urandom);
            be = ($urandom_range(0, 9) < 8) ? 4'b0001 : 4'($urandom);
            if (op < 2)       cpu_reset();
            else if (op < 40) step(1, 0, a, be, 32'h0, 1'($urandom));
            else if (op < 75) step(0, 1, a, be, $urandom, 1'($urandom));
            else              step(0, 0, a, be, $urandom, 1'($urandom));
        end

        idle(6);
        finish_run();
    end

endmodule